// File: doc/BRIEF.md
# Integer-Ratio Stream Width Downsizer

This block connects a wide ready/valid byte stream to a narrower one whose width divides the wide width exactly. Each wide beat is captured in a single handshake into a holding register. It is then handed out as a series of narrow slices, starting with the lowest-addressed bytes. Every slice carries its data, the byte-valid bits for its own bytes, and an end-of-packet flag.

A wide beat that is only partly filled does not have to be drained in full. The block emits slices up to and including the highest slice that contains a valid byte, and then stops. The end-of-packet flag moves onto that final emitted slice. When the final slice of one beat is taken, the next wide beat can be accepted in the same cycle, so a stream of full beats keeps the narrow side busy with no idle cycles.

The ratio between the two widths is fixed when the design is elaborated. A small phase counter picks the active slice, so no arithmetic is done at run time.

Top module: `stream_downsizer`

## Requirements
- R1: A wide beat is accepted (inValid and inReady both high at a clock edge) exactly once. inReady is high whenever nothing is held, and low while a held beat still has slices to emit other than the one being taken in the current cycle.
- R2: Slice k of a held beat carries bits [k*SLICE_W +: SLICE_W] of the wide data, where SLICE_W = 8*SLICE_BYTES. Slices go out in order k = 0, 1, 2, and so on. With one-byte slices, 0x04030201 therefore produces 0x01, 0x02, 0x03, 0x04.
- R3: Bit i of a keep vector marks byte i as valid. The keep output of slice k equals inKeep[k*SLICE_BYTES +: SLICE_BYTES] of its beat, including slices whose keep bits are all zero.
- R4: outLast is high only on the final emitted slice of a beat that arrived with inLast high. It is low on every other slice.
- R5: The final emitted slice is the highest slice whose keep bits are not all zero. Slices above it are never emitted.
- R6: A beat with all keep bits zero and inLast high produces exactly one slice: slice 0 with keep zero and outLast high.
- R7: A beat with all keep bits zero and inLast low is accepted and produces no output.
- R8: When the final slice of a held beat is taken in the same cycle that a new beat is accepted, the first slice of the new beat is offered in the next cycle. There is no idle cycle between them.
- R9: While outValid is high and outReady is low, outValid stays high and outData, outKeep and outLast stay unchanged.
- R10: During and right after reset, outValid is low and inReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Wide beat offered |
| inReady | output | 1 | Wide beat can be taken this cycle |
| inData | input | RATIO*SLICE_BYTES*8 | Wide beat data |
| inKeep | input | RATIO*SLICE_BYTES | Byte-valid bits of the wide beat |
| inLast | input | 1 | Wide beat ends a packet |
| outValid | output | 1 | Narrow slice offered |
| outReady | input | 1 | Downstream takes the narrow slice |
| outData | output | SLICE_BYTES*8 | Narrow slice data |
| outKeep | output | SLICE_BYTES | Byte-valid bits of the slice |
| outLast | output | 1 | Slice ends a packet |

## Verification
The assertions assume the downstream side does not rely on outReady to decide whether to present data. They also assume the upstream holds inData, inKeep and inLast steady while it offers a beat, because the drop and load checks read those values in the accept cycle.

The stimulus changes inputs only at the falling clock edge. It keeps each beat in place until it observes inReady, and it drives outReady from a fixed pattern that never depends on outValid. Backpressure patterns include always ready, ready two cycles out of three, and stalled. Under all of them the hold and stability properties sit within the protocol the design expects.

// File: rtl/dsz_pkg.sv
package dsz_pkg;
  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;     // capture the offered wide beat, restart at slice 0
    logic advance;  // step to the next slice of the held beat
  } dszStrobes_t;
endpackage

// File: rtl/dsz_lane_scan.sv
module dsz_lane_scan #(
  parameter int RATIO       = 4,
  parameter int SLICE_BYTES = 1,
  parameter int IDX_W       = 2
) (
  input  logic [RATIO*SLICE_BYTES-1:0] keep,
  output logic                         anyKeep,
  output logic [IDX_W-1:0]             lastIdx
);
  logic [RATIO-1:0] groupHit;

  // One OR-reduction per slice-sized lane group
  for (genvar g = 0; g < RATIO; g++) begin : gHit
    assign groupHit[g] = |keep[g*SLICE_BYTES +: SLICE_BYTES];
  end

  assign anyKeep = |groupHit;

  // Highest lane group holding a valid byte; 0 when none
  always_comb begin
    lastIdx = '0;
    for (int g = 0; g < RATIO; g++) begin
      if (groupHit[g]) lastIdx = IDX_W'(g);
    end
  end
endmodule

// File: rtl/dsz_control.sv
module dsz_control
  import dsz_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        anyKeep,
  input  logic        outReady,
  input  logic        isFinal,
  output logic        inReady,
  output logic        outValid,
  output dszStrobes_t strobes
);
  logic full;
  logic finishing;
  logic accept;

  assign outValid  = full;
  assign finishing = full && outReady && isFinal;
  assign inReady   = !full || finishing;
  assign accept    = inValid && inReady;

  // A beat with no valid byte and no packet end is swallowed
  assign strobes.load    = accept && (anyKeep || inLast);
  assign strobes.advance = full && outReady && !isFinal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full <= 1'b0;
    end else if (strobes.load) begin
      full <= 1'b1;
    end else if (finishing) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/dsz_datapath.sv
module dsz_datapath
  import dsz_pkg::*;
#(
  parameter int RATIO       = 4,
  parameter int SLICE_BYTES = 1,
  parameter int IDX_W       = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  dszStrobes_t                    strobes,
  input  logic [RATIO*SLICE_BYTES*8-1:0] inData,
  input  logic [RATIO*SLICE_BYTES-1:0]   inKeep,
  input  logic                           inLast,
  input  logic [IDX_W-1:0]               lastIdxIn,
  output logic                           isFinal,
  output logic [SLICE_BYTES*8-1:0]       outData,
  output logic [SLICE_BYTES-1:0]         outKeep,
  output logic                           outLast
);
  localparam int SLICE_W = SLICE_BYTES * 8;
  localparam int WIDE_W  = RATIO * SLICE_W;
  localparam int WIDE_B  = RATIO * SLICE_BYTES;

  logic [WIDE_W-1:0] holdData;
  logic [WIDE_B-1:0] holdKeep;
  logic              holdLast;
  logic [IDX_W-1:0]  holdIdx;
  logic [IDX_W-1:0]  phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdData <= '0;
      holdKeep <= '0;
      holdLast <= 1'b0;
      holdIdx  <= '0;
      phase    <= '0;
    end else if (strobes.load) begin
      holdData <= inData;
      holdKeep <= inKeep;
      holdLast <= inLast;
      holdIdx  <= lastIdxIn;
      phase    <= '0;
    end else if (strobes.advance) begin
      phase <= phase + IDX_W'(1);
    end
  end

  assign isFinal = (phase == holdIdx);
  assign outData = holdData[phase*SLICE_W +: SLICE_W];
  assign outKeep = holdKeep[phase*SLICE_BYTES +: SLICE_BYTES];
  assign outLast = holdLast && isFinal;
endmodule

// File: rtl/stream_downsizer.sv
module stream_downsizer
  import dsz_pkg::*;
#(
  parameter int SLICE_BYTES = 1,
  parameter int RATIO       = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           inValid,
  output logic                           inReady,
  input  logic [RATIO*SLICE_BYTES*8-1:0] inData,
  input  logic [RATIO*SLICE_BYTES-1:0]   inKeep,
  input  logic                           inLast,
  output logic                           outValid,
  input  logic                           outReady,
  output logic [SLICE_BYTES*8-1:0]       outData,
  output logic [SLICE_BYTES-1:0]         outKeep,
  output logic                           outLast
);
  localparam int IDX_W = (RATIO > 1) ? $clog2(RATIO) : 1;

  dszStrobes_t     strobes;
  logic            anyKeep;
  logic [IDX_W-1:0] lastIdx;
  logic            isFinal;

  dsz_lane_scan #(.RATIO(RATIO), .SLICE_BYTES(SLICE_BYTES), .IDX_W(IDX_W)) uScan (
    .keep    (inKeep),
    .anyKeep (anyKeep),
    .lastIdx (lastIdx)
  );

  dsz_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .anyKeep  (anyKeep),
    .outReady (outReady),
    .isFinal  (isFinal),
    .inReady  (inReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  dsz_datapath #(.RATIO(RATIO), .SLICE_BYTES(SLICE_BYTES), .IDX_W(IDX_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .inData    (inData),
    .inKeep    (inKeep),
    .inLast    (inLast),
    .lastIdxIn (lastIdx),
    .isFinal   (isFinal),
    .outData   (outData),
    .outKeep   (outKeep),
    .outLast   (outLast)
  );
endmodule

// File: rtl/dsz_checker.sv
module dsz_checker #(
  parameter int SLICE_BYTES = 1,
  parameter int RATIO       = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           inValid,
  input logic                           inReady,
  input logic [RATIO*SLICE_BYTES*8-1:0] inData,
  input logic [RATIO*SLICE_BYTES-1:0]   inKeep,
  input logic                           inLast,
  input logic                           outValid,
  input logic                           outReady,
  input logic [SLICE_BYTES*8-1:0]       outData,
  input logic [SLICE_BYTES-1:0]         outKeep,
  input logic                           outLast
);
  // Stalled slice must not move (R9)
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outKeep) && $stable(outLast)));

  // Empty holding register always takes a beat (R1)
  assert_ready_when_empty_R1: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> inReady);

  // No second accept while a slice is stalled (R1)
  assert_no_accept_stalled_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  // An accepted beat with content is offered next cycle, no bubble (R8)
  assert_no_bubble_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && ((|inKeep) || inLast)) |=> outValid);

  // Empty non-final beat into idle block leaves it idle (R7)
  assert_drop_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!outValid && inValid && (inKeep == '0) && !inLast) |=> !outValid);
endmodule

bind stream_downsizer dsz_checker #(.SLICE_BYTES(SLICE_BYTES), .RATIO(RATIO)) uChk (.*);

// File: tb/tb_stream_downsizer.sv
module tb_stream_downsizer;
  localparam int SB    = 1;
  localparam int RATIO = 4;
  localparam int WW    = RATIO * SB * 8;
  localparam int WB    = RATIO * SB;

  typedef struct packed {
    logic [WW-1:0] data;
    logic [WB-1:0] keep;
    logic          last;
    logic [3:0]    req;
  } vec_t;

  // Table of stimulus; expected slices are derived from the requirements
  localparam vec_t VECS [9] = '{
    '{32'h04030201, 4'hF, 1'b0, 4'd2},  // R2 lowest lane first
    '{32'h08070605, 4'hF, 1'b1, 4'd4},  // R4 last on final slice
    '{32'h0C0B0A09, 4'h3, 1'b1, 4'd5},  // R5 stop after slice 1
    '{32'h11223344, 4'h1, 1'b0, 4'd5},  // R5 single slice
    '{32'hAABBCCDD, 4'h5, 1'b1, 4'd3},  // R3 sparse keep, stop at slice 2
    '{32'h55667788, 4'h0, 1'b1, 4'd6},  // R6 empty with last
    '{32'h99999999, 4'h0, 1'b0, 4'd7},  // R7 dropped
    '{32'hDEADBEEF, 4'h8, 1'b1, 4'd3},  // R3 only top lane valid
    '{32'h12345678, 4'hE, 1'b0, 4'd3}   // R3 lane 0 invalid
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [WW-1:0] inData = '0;
  logic [WB-1:0] inKeep = '0;
  logic          inLast = 1'b0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [7:0]    outData;
  logic [0:0]    outKeep;
  logic          outLast;

  stream_downsizer #(.SLICE_BYTES(SB), .RATIO(RATIO)) dut (.*);

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int failures = 0;
  int cycle = 0;
  int bpMode = 0;
  bit done = 1'b0;

  logic [7:0] expData [512];
  logic       expKeep [512];
  logic       expLast [512];
  int         expReq  [512];
  int         expCnt = 0;
  logic [7:0] rxData  [512];
  logic       rxKeep  [512];
  logic       rxLast  [512];
  int         rxCycle [512];
  int         rxCnt = 0;

  always @(posedge clk) cycle <= cycle + 1;

  always @(negedge clk) begin
    case (bpMode)
      0:       outReady = 1'b1;
      1:       outReady = (cycle % 3) != 0;
      default: outReady = 1'b0;
    endcase
  end

  // Monitor samples 1 ns after the falling edge, well before the next rise
  always @(negedge clk) begin
    #1;
    if (rstN && outValid && outReady && rxCnt < 512) begin
      rxData[rxCnt]  = outData;
      rxKeep[rxCnt]  = outKeep[0];
      rxLast[rxCnt]  = outLast;
      rxCycle[rxCnt] = cycle;
      rxCnt++;
    end
  end

  task automatic checkVal(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Model: slices up to highest valid lane group; empty+last gives slice 0
  task automatic addExpected(logic [WW-1:0] d, logic [WB-1:0] k, logic l, int req);
    int hi = -1;
    int n;
    for (int g = 0; g < RATIO; g++) if (k[g]) hi = g;
    n = (hi >= 0) ? hi + 1 : (l ? 1 : 0);
    for (int i = 0; i < n; i++) begin
      expData[expCnt] = d[8*i +: 8];
      expKeep[expCnt] = k[i];
      expLast[expCnt] = l && (i == n - 1);
      expReq[expCnt]  = req;
      expCnt++;
    end
  endtask

  task automatic sendBeat(logic [WW-1:0] d, logic [WB-1:0] k, logic l);
    inData = d; inKeep = k; inLast = l; inValid = 1'b1;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
  endtask

  task automatic waitDrain();
    inValid = 1'b0;
    for (int i = 0; i < 300 && rxCnt < expCnt; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic compareAll();
    checkVal("R5", "slice count", rxCnt, expCnt);
    for (int i = 0; i < expCnt && i < rxCnt; i++) begin
      checkVal($sformatf("R%0d", expReq[i]), $sformatf("data[%0d]", i), rxData[i], expData[i]);
      checkVal($sformatf("R%0d", expReq[i]), $sformatf("keep[%0d]", i), rxKeep[i], expKeep[i]);
      checkVal($sformatf("R%0d", expReq[i]), $sformatf("last[%0d]", i), rxLast[i], expLast[i]);
    end
    rxCnt = 0;
    expCnt = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=done", cycle);
    finishRun();
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    checkVal("R10", "outValid in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    checkVal("R10", "outValid after reset", outValid, 0);
    checkVal("R10", "inReady after reset", inReady, 1);

    // Table walk under periodic backpressure (R2 R3 R4 R5 R6 R7)
    bpMode = 1;
    @(negedge clk);
    for (int v = 0; v < 9; v++) begin
      addExpected(VECS[v].data, VECS[v].keep, VECS[v].last, int'(VECS[v].req));
      sendBeat(VECS[v].data, VECS[v].keep, VECS[v].last);
    end
    waitDrain();
    compareAll();

    // R7: dropped beat into idle block, observed at the ports
    bpMode = 0;
    sendBeat(32'h00000000, 4'h0, 1'b0);
    inValid = 1'b0;
    repeat (6) @(negedge clk);
    #1;
    checkVal("R7", "slices after dropped beat", rxCnt, 0);
    checkVal("R7", "outValid after dropped beat", outValid, 0);
    checkVal("R7", "inReady after dropped beat", inReady, 1);

    // R9 and R1: stalled slice is held, no further accept
    bpMode = 2;
    @(negedge clk);
    addExpected(32'h44332211, 4'hF, 1'b1, 9);
    sendBeat(32'h44332211, 4'hF, 1'b1);
    inData = 32'hCAFEF00D; inKeep = 4'hF; inLast = 1'b0; // offered, must wait
    #1;
    held = outData;
    repeat (5) @(negedge clk);
    #1;
    checkVal("R9", "outValid under stall", outValid, 1);
    checkVal("R9", "outData under stall", outData, held);
    checkVal("R2", "first slice under stall", outData, 8'h11);
    checkVal("R1", "inReady while holding", inReady, 0);
    inValid = 1'b0;
    bpMode = 0;
    waitDrain();
    compareAll();

    // R8: back-to-back full beats drain without idle cycles
    addExpected(32'hA3A2A1A0, 4'hF, 1'b0, 8);
    addExpected(32'hB3B2B1B0, 4'hF, 1'b1, 8);
    sendBeat(32'hA3A2A1A0, 4'hF, 1'b0);
    sendBeat(32'hB3B2B1B0, 4'hF, 1'b1);
    waitDrain();
    for (int i = 0; i + 1 < rxCnt; i++)
      checkVal("R8", $sformatf("gap after slice %0d", i), rxCycle[i+1] - rxCycle[i], 1);
    compareAll();

    finishRun();
  end
endmodule